// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable stand-in for a 16-bit static memory. The memory has an asynchronous control set: chip select, write strobe and read gate, all active low, plus one active-low select for each byte lane. The controls and the address are sampled on a system clock. The block decodes the controls into one of four modes: standby, outputs off, read and write. Each 8-bit lane gets its own read data and its own drive-enable flag. There are no internal tri-states, so a pad ring or a bus model can build the high-impedance behaviour from `dout` and `dout_en`.

A write opens when chip select, write strobe and a lane select are all low together, which is the write window of that lane. Data, address and lane mask are captured in every cycle of the window. The array is updated once, when the window closes, with the values from the last cycle of the window. The window closes when any of chip select, write strobe or that lane's select rises. A `wr_inhibit` input stands for a supply below the safe write level. If `wr_inhibit` is high in any cycle of a window, that window is cancelled. Reads return the stored word one clock after the controls and address are sampled. The array is built as one inferable RAM per lane.

Top module: `amem_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dout_en` is 2'b00.
- R2: With `ce_n` high, `dout_en` is 2'b00 one clock later, and no location changes, whatever `we_n`, `oe_n`, `bsel_n`, `addr` and `din` are.
- R3: With `ce_n` low, `we_n` high and `oe_n` high, `dout_en` is 2'b00. With both `bsel_n` bits high, `dout_en` is 2'b00 and no write takes place, whatever the values of `we_n` and `oe_n`.
- R4: When `ce_n` is low, `oe_n` is low and `we_n` is high, `dout_en` equals the inverse of the sampled `bsel_n` one clock later. Each enabled lane of `dout` then carries the stored byte at the sampled `addr`.
- R5: When `ce_n` and `we_n` are both low, `dout_en` is 2'b00 one clock later, even with `oe_n` low. The write updates only the lanes whose select is low, and `oe_n` has no effect on the write.
- R6: A lane's write takes effect at the first sampled cycle in which `ce_n`, `we_n` or that lane's select is high again. The stored value is the `din` and `addr` of the last cycle of the window.
- R7: If `wr_inhibit` is high in any cycle of a write window, or in the cycle that closes it, no lane of that window is updated.
- R8: Lane 0 is `din`/`dout` bits 7:0 and is selected by `bsel_n[0]`. Lane 1 is bits 15:8 and is selected by `bsel_n[1]`.
- R9: When one lane's select rises while the other lane's window stays open, the first lane is written at once with its last captured byte. The other lane keeps capturing until its own window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read gate, active low |
| bsel_n | input | 2 | Lane selects, active low (bit 0 = bits 7:0) |
| addr | input | 8 | Word address |
| din | input | 16 | Write data |
| wr_inhibit | input | 1 | Low-supply write block, active high |
| dout | output | 16 | Registered read data |
| dout_en | output | 2 | Per-lane drive enable (else high impedance) |

## Verification
The hardest case to reach is a split window. In it, the upper lane's select rises while the strobe and the lower lane's select stay low, and `din` changes in the same cycle. The upper lane must take the byte from the cycle before, and the lower lane must go on capturing. The bench drives one control change per clock to build this sequence, then reads the word back. The case where inhibit is raised for one cycle in the middle of a window is reached in the same way. Rewriting a location already read and reading it again shows any stray update.

// File: rtl/amem_pkg.sv
package amem_pkg;
  typedef enum logic [1:0] {
    MD_STBY  = 2'd0,
    MD_OFF   = 2'd1,
    MD_READ  = 2'd2,
    MD_WRITE = 2'd3
  } amem_mode_e;
endpackage

// File: rtl/amem_decode.sv
module amem_decode #(
  parameter int LANES = 2
) (
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] rd_lane,
  output logic [LANES-1:0] wr_lane
);
  import amem_pkg::*;

  amem_mode_e mode;

  // Standby dominates, then all-lanes-deselected, then write over read.
  always_comb begin
    if (ce_n)             mode = MD_STBY;
    else if (&bsel_n)     mode = MD_OFF;
    else if (!we_n)       mode = MD_WRITE;
    else if (!oe_n)       mode = MD_READ;
    else                  mode = MD_OFF;
  end

  always_comb begin
    rd_lane = (mode == MD_READ)  ? ~bsel_n : '0;
    wr_lane = (mode == MD_WRITE) ? ~bsel_n : '0;
  end
endmodule

// File: rtl/amem_wcap.sv
module amem_wcap #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int AW     = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0]              wr_lane,
  input  logic                          inhibit,
  input  logic [AW-1:0]                 addr,
  input  logic [LANES-1:0][LANE_W-1:0]  din,
  output logic [LANES-1:0]              commit,
  output logic [AW-1:0]                 cap_addr,
  output logic [LANES-1:0][LANE_W-1:0]  cap_data
);
  logic [LANES-1:0] act_q;
  logic             poison_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      poison_q <= 1'b0;
    end else begin
      act_q    <= wr_lane;
      poison_q <= (|wr_lane) ? (poison_q | inhibit) : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (|wr_lane) cap_addr <= addr;
    for (int l = 0; l < LANES; l++)
      if (wr_lane[l]) cap_data[l] <= din[l];
  end

  // A lane commits on the cycle its window has just closed.
  always_comb commit = act_q & ~wr_lane & {LANES{~poison_q & ~inhibit}};

  p_poison_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (|wr_lane && inhibit) |=> (commit == '0));
endmodule

// File: rtl/amem_lane.sv
module amem_lane #(
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [LANE_W-1:0] rd_data
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/amem_top.sv
module amem_top #(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             wr_inhibit,
  output logic [DW-1:0]    dout,
  output logic [LANES-1:0] dout_en
);
  logic [LANES-1:0]             rd_lane, wr_lane, commit;
  logic [AW-1:0]                cap_addr;
  logic [LANES-1:0][LANE_W-1:0] din_l, cap_data, rd_l;

  assign din_l = din;

  amem_decode #(.LANES(LANES)) u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .bsel_n(bsel_n),
    .rd_lane(rd_lane), .wr_lane(wr_lane)
  );

  amem_wcap #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_wcap (
    .clk(clk), .rst(rst), .wr_lane(wr_lane), .inhibit(wr_inhibit),
    .addr(addr), .din(din_l), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    amem_lane #(.LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk(clk), .wr_en(commit[g]), .wr_addr(cap_addr),
      .wr_data(cap_data[g]), .rd_addr(addr), .rd_data(rd_l[g])
    );
  end

  assign dout = rd_l;

  always_ff @(posedge clk) begin
    if (rst) dout_en <= '0;
    else     dout_en <= rd_lane;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (dout_en == '0));
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (dout_en == '0));
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |=> (dout_en == '0));
  p_read_lanes_r4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> (dout_en == ~$past(bsel_n)));
  p_commit_after_window_r6: assert property (@(posedge clk) disable iff (rst)
    (|commit) |-> $past(!ce_n && !we_n));
  p_inhibit_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    wr_inhibit |-> (commit == '0));
endmodule

// File: tb/test_amem_top.sv
module test_amem_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wr_inhibit = 1'b0;
  logic [1:0]  bsel_n = 2'b11;
  logic [7:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amem_top i_amem_top (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .bsel_n(bsel_n), .addr(addr), .din(din), .wr_inhibit(wr_inhibit),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one set of pins at the falling edge; return just after the next rising edge.
  task automatic step(input logic ce, input logic we, input logic oe, input logic [1:0] bs,
                      input logic [7:0] a, input logic [15:0] d, input logic inh);
    @(negedge clk);
    ce_n = ce; we_n = we; oe_n = oe; bsel_n = bs; addr = a; din = d; wr_inhibit = inh;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    step(1, 1, 1, 2'b11, 8'h00, 16'h0000, 0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] bs,
                        input logic [15:0] exp);
    logic [15:0] m;
    step(0, 1, 0, bs, a, 16'h0000, 0);
    m = {{8{~bs[1]}}, {8{~bs[0]}}};
    chk({req, " lane enables"}, {30'd0, dout_en}, {30'd0, ~bs});
    chk({req, " data"}, {16'd0, dout & m}, {16'd0, exp & m});
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] bs,
                    input logic oe);
    step(0, 0, oe, bs, a, d, 0);
    step(0, 1, 1, bs, a, d, 0);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 in reset", {30'd0, dout_en}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", {30'd0, dout_en}, 32'd0);
  endtask

  task automatic t_word();
    wr(8'h10, 16'hA55A, 2'b00, 1);
    rd_chk("R4 word read", 8'h10, 2'b00, 16'hA55A);
  endtask

  task automatic t_lanes();
    wr(8'h10, 16'h1234, 2'b10, 1);          // R8: only bits 7:0 written
    rd_chk("R8 lower lane read", 8'h10, 2'b10, 16'hA534);
    rd_chk("R4 upper lane read", 8'h10, 2'b01, 16'hA534);
    rd_chk("R5 byte write kept other lane", 8'h10, 2'b00, 16'hA534);
  endtask

  task automatic t_standby();
    step(1, 0, 0, 2'b00, 8'h10, 16'hFFFF, 0);
    chk("R2 standby lanes off", {30'd0, dout_en}, 32'd0);
    step(1, 1, 0, 2'b00, 8'h10, 16'hFFFF, 0);
    idle();
    rd_chk("R2 standby no write", 8'h10, 2'b00, 16'hA534);
  endtask

  task automatic t_outoff();
    step(0, 1, 1, 2'b00, 8'h10, 16'h0000, 0);
    chk("R3 gate high lanes off", {30'd0, dout_en}, 32'd0);
    step(0, 1, 0, 2'b11, 8'h10, 16'h0000, 0);
    chk("R3 no lane selected off", {30'd0, dout_en}, 32'd0);
    step(0, 0, 1, 2'b11, 8'h10, 16'h0000, 0);
    step(0, 1, 1, 2'b11, 8'h10, 16'h0000, 0);
    idle();
    rd_chk("R3 no lane no write", 8'h10, 2'b00, 16'hA534);
  endtask

  task automatic t_write_gate_low();
    step(0, 0, 0, 2'b00, 8'h20, 16'hBEEF, 0);
    chk("R5 write with gate low lanes off", {30'd0, dout_en}, 32'd0);
    step(0, 1, 1, 2'b00, 8'h20, 16'hBEEF, 0);
    idle();
    rd_chk("R5 write with gate low stored", 8'h20, 2'b00, 16'hBEEF);
  endtask

  task automatic t_last_data();
    step(0, 0, 1, 2'b00, 8'h30, 16'h1111, 0);
    step(0, 0, 1, 2'b00, 8'h30, 16'h2222, 0);
    step(1, 0, 1, 2'b00, 8'h30, 16'h3333, 0);   // chip select ends window
    idle();
    rd_chk("R6 last window data kept", 8'h30, 2'b00, 16'h2222);
  endtask

  task automatic t_inhibit();
    step(0, 0, 1, 2'b00, 8'h20, 16'h0000, 0);
    step(0, 0, 1, 2'b00, 8'h20, 16'h0000, 1);
    step(0, 0, 1, 2'b00, 8'h20, 16'h0000, 0);
    step(0, 1, 1, 2'b00, 8'h20, 16'h0000, 0);
    idle();
    rd_chk("R7 mid-window inhibit", 8'h20, 2'b00, 16'hBEEF);
    step(0, 0, 1, 2'b00, 8'h20, 16'h5555, 1);
    step(0, 1, 1, 2'b00, 8'h20, 16'h5555, 1);
    idle();
    rd_chk("R7 inhibited throughout", 8'h20, 2'b00, 16'hBEEF);
  endtask

  task automatic t_split();
    step(0, 0, 1, 2'b00, 8'h40, 16'hAABB, 0);
    step(0, 0, 1, 2'b10, 8'h40, 16'hCCDD, 0);   // upper select rises
    step(0, 1, 1, 2'b10, 8'h40, 16'hEEFF, 0);   // strobe rises, lower ends
    idle();
    rd_chk("R9 split window", 8'h40, 2'b00, 16'hAADD);
  endtask

  initial begin
    t_reset();
    t_word();
    t_lanes();
    t_standby();
    t_outoff();
    t_write_gate_low();
    t_last_data();
    t_inhibit();
    t_split();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule